// File: doc/BRIEF.md
# I2C Transmit Byte Handoff Controller

This block sits between the processor-facing transmit holding byte of an I2C controller and the serial shift stage driven by the bit-level engine. It holds the byte written by software. It decides, from event strobes raised by the bit engine, the cycle in which that byte moves into the shifter. The decision rests on the operating mode (master or slave), the direction bit of the current transfer, and the acknowledge level that the far end returned. When the far end refuses a byte, the block asks the bit engine to end the transfer: as a slave it lets go of SDA, as a master it asks for a STOP or repeated START. It then loads nothing more until a fresh address phase.

A transmit-empty flag tells software that the held byte has gone to the shifter and a new one may be written. All decisions are made in the cycle of the strobe. `load_strobe`, `release_sda` and `stop_req` are combinational on the strobe cycle. `shift_data` and `tx_empty` change at the clock edge that ends it.

The state machine has four states. `ST_IDLE` means no transmit transfer is active. `ST_SLV_TX` means a slave transmit is in progress. `ST_MST_TX` means a master transmit is in progress. `ST_HALT` means the last byte was refused and loading is frozen.

It has these transitions:
- Any state goes to `ST_IDLE` while disabled.
- A slave call with the read direction goes to `ST_SLV_TX`, and a slave call with the write direction goes to `ST_IDLE`.
- A master address sent with the write direction and acknowledged goes to `ST_MST_TX`. The same address phase with no acknowledge goes to `ST_HALT`. A master address sent with the read direction goes to `ST_IDLE`.
- A byte done with no acknowledge goes from `ST_SLV_TX` or `ST_MST_TX` to `ST_HALT`.
- A byte done with acknowledge keeps `ST_SLV_TX` or `ST_MST_TX`.
- In `ST_IDLE` and `ST_HALT`, byte done has no effect.

Top module: `i2c_tx_handoff`

## Requirements
- R1: While reset is asserted and after it is released, the holding byte and `shift_data` are 0, `tx_empty` is 0, and `load_strobe`, `release_sda` and `stop_req` are 0.
- R2: In slave mode (`master_mode`=0), `addr_match` with `dir_read`=1 raises `load_strobe` in the same cycle, and `shift_data` holds the holding byte after that clock edge. `addr_match` with `dir_read`=0 loads nothing.
- R3: During a slave transmit, `byte_done` with `rx_ack`=0 (0 means acknowledge) raises `load_strobe`.
- R4: During a slave transmit, `byte_done` with `rx_ack`=1 raises `release_sda` and not `load_strobe`. Later `byte_done` strobes load nothing until the next `addr_match` with `dir_read`=1.
- R5: In master mode (`master_mode`=1), `addr_sent` with `dir_read`=0 and `rx_ack`=0 raises `load_strobe`. `addr_sent` with `dir_read`=1 loads nothing.
- R6: During a master transmit, `byte_done` with `rx_ack`=0 raises `load_strobe`.
- R7: In master mode, a refused address (`addr_sent`, `dir_read`=0, `rx_ack`=1) or a refused byte (`byte_done`, `rx_ack`=1) raises `stop_req` and not `load_strobe`. Later `byte_done` strobes load nothing until the next `addr_sent`.
- R8: `tx_empty` becomes 1 at the edge that ends a load cycle. It becomes 0 at the edge that ends an accepted write. A write in the same cycle as a load wins for `tx_empty`, and the load takes the byte held before the write.
- R9: A refusal cycle never sets `tx_empty`: a 0 flag stays 0 through it.
- R10: While `enable`=0, `cpu_wr` leaves the holding byte unchanged, every strobe is ignored, and the transfer state returns to idle.
- R11: `addr_match` is ignored in master mode, and `addr_sent` is ignored in slave mode. At most one of `load_strobe`, `release_sda` and `stop_req` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; gates writes and events |
| master_mode | input | 1 | 1 = master, 0 = slave |
| dir_read | input | 1 | Direction bit of the address phase, 1 = read |
| cpu_wr | input | 1 | Write strobe for the holding byte |
| cpu_wdata | input | DW | Byte written by software |
| addr_match | input | 1 | Strobe: own address recognised (slave) |
| addr_sent | input | 1 | Strobe: address byte sent and acknowledge sampled (master) |
| byte_done | input | 1 | Strobe: data byte shifted and acknowledge sampled |
| rx_ack | input | 1 | Acknowledge level sampled from the far end, 0 = ACK |
| load_strobe | output | 1 | Move holding byte into shifter this cycle |
| shift_data | output | DW | Byte last handed to the shifter |
| release_sda | output | 1 | Slave lets go of SDA after a refused byte |
| stop_req | output | 1 | Master asks for STOP or repeated START |
| tx_empty | output | 1 | Holding byte has been handed off |

## Verification
The assertions assume that the event strobes are single-cycle pulses and that `rx_ack` is valid in each strobe cycle. They also assume that `addr_match` and `addr_sent` never rise in the same cycle as `byte_done`. The stimulus drives exactly one event per cycle, changes inputs on the falling edge, and returns every strobe to 0 before the next event. Mode and direction change only in cycles with no event, or together with the address strobe that they qualify.

// File: rtl/i2c_txh_pkg.sv
package i2c_txh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SLV_TX = 2'd1,
        ST_MST_TX = 2'd2,
        ST_HALT   = 2'd3
    } txh_state_e;
endpackage

// File: rtl/txh_hold_reg.sv
module txh_hold_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          load,
    output logic [DW-1:0] shift_data,
    output logic          tx_empty
);
    logic [DW-1:0] hold_q;
    logic [DW-1:0] shift_q;
    logic          empty_q;
    logic          wr_ok;

    assign wr_ok = cpu_wr && enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            shift_q <= '0;
            empty_q <= 1'b0;
        end else begin
            if (load)  shift_q <= hold_q;
            if (wr_ok) hold_q  <= cpu_wdata;
            if (wr_ok)     empty_q <= 1'b0;
            else if (load) empty_q <= 1'b1;
        end
    end

    assign shift_data = shift_q;
    assign tx_empty   = empty_q;

    a_r8_set_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_ok) |=> tx_empty);
    a_r8_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> !tx_empty);
    a_r2_shift_gets_hold: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (shift_data == $past(hold_q)));
    a_r10_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !enable) |=> $stable(hold_q));
endmodule

// File: rtl/txh_handoff_fsm.sv
module txh_handoff_fsm
    import i2c_txh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic master_mode,
    input  logic dir_read,
    input  logic addr_match,
    input  logic addr_sent,
    input  logic byte_done,
    input  logic rx_ack,
    output logic load_o,
    output logic release_o,
    output logic stop_o
);
    txh_state_e st_q, st_d;
    logic mst_call, slv_call;

    assign mst_call = enable && master_mode && addr_sent;
    assign slv_call = enable && !master_mode && addr_match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = ST_IDLE;
        end else if (mst_call) begin
            if (dir_read)     st_d = ST_IDLE;
            else if (!rx_ack) st_d = ST_MST_TX;
            else              st_d = ST_HALT;
        end else if (slv_call) begin
            st_d = dir_read ? ST_SLV_TX : ST_IDLE;
        end else if (byte_done) begin
            unique case (st_q)
                ST_SLV_TX, ST_MST_TX: if (rx_ack) st_d = ST_HALT;
                ST_IDLE, ST_HALT:     st_d = st_q;
                default:              st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load_o    = 1'b0;
        release_o = 1'b0;
        stop_o    = 1'b0;
        if (mst_call) begin
            if (!dir_read) begin
                if (!rx_ack) load_o = 1'b1;
                else         stop_o = 1'b1;
            end
        end else if (slv_call) begin
            load_o = dir_read;
        end else if (enable && byte_done) begin
            unique case (st_q)
                ST_SLV_TX: begin
                    load_o    = !rx_ack;
                    release_o = rx_ack;
                end
                ST_MST_TX: begin
                    load_o = !rx_ack;
                    stop_o = rx_ack;
                end
                ST_IDLE, ST_HALT: ;
                default: ;
            endcase
        end
    end

    a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_o, release_o, stop_o}));
    a_r4_frozen_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> (load_o -> (addr_match || addr_sent)));
    a_r7_frozen_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> (load_o -> (addr_match || addr_sent)));
    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !(load_o || release_o || stop_o));
    a_r11_release_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> !master_mode);
endmodule

// File: rtl/i2c_tx_handoff.sv
module i2c_tx_handoff #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          master_mode,
    input  logic          dir_read,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          addr_match,
    input  logic          addr_sent,
    input  logic          byte_done,
    input  logic          rx_ack,
    output logic          load_strobe,
    output logic [DW-1:0] shift_data,
    output logic          release_sda,
    output logic          stop_req,
    output logic          tx_empty
);
    logic load_w;

    txh_handoff_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .master_mode(master_mode),
        .dir_read   (dir_read),
        .addr_match (addr_match),
        .addr_sent  (addr_sent),
        .byte_done  (byte_done),
        .rx_ack     (rx_ack),
        .load_o     (load_w),
        .release_o  (release_sda),
        .stop_o     (stop_req)
    );

    txh_hold_reg #(.DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .load      (load_w),
        .shift_data(shift_data),
        .tx_empty  (tx_empty)
    );

    assign load_strobe = load_w;

    a_r9_refusal_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((release_sda || stop_req) && !tx_empty) |=> !tx_empty);
endmodule

// File: tb/tb_i2c_tx_handoff.sv
module tb_i2c_tx_handoff;
    localparam int DW = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, master_mode = 1'b0, dir_read = 1'b0, cpu_wr = 1'b0;
    logic [DW-1:0] cpu_wdata = '0;
    logic addr_match = 1'b0, addr_sent = 1'b0, byte_done = 1'b0, rx_ack = 1'b0;
    logic load_strobe, release_sda, stop_req, tx_empty;
    logic [DW-1:0] shift_data;
    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    i2c_tx_handoff #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master_mode(master_mode),
        .dir_read(dir_read), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .addr_match(addr_match), .addr_sent(addr_sent), .byte_done(byte_done),
        .rx_ack(rx_ack), .load_strobe(load_strobe), .shift_data(shift_data),
        .release_sda(release_sda), .stop_req(stop_req), .tx_empty(tx_empty)
    );

    // bits: [8] master [7] dir_read [6] addr_match [5] addr_sent [4] byte_done
    //       [3] rx_ack [2] exp load [1] exp release [0] exp stop
    localparam logic [8:0] VEC [16] = '{
        9'b0_0_1_0_0_0_000, // R2 slave write call: no load
        9'b0_0_0_0_1_0_000, // R4 idle, byte_done ignored
        9'b0_1_1_0_0_0_100, // R2 slave read call
        9'b0_0_0_0_1_0_100, // R3 ack continues
        9'b0_0_0_0_1_1_010, // R4 nack releases
        9'b0_0_0_0_1_0_000, // R4 frozen
        9'b0_1_1_0_0_0_100, // R4 new call unfreezes
        9'b0_0_0_0_1_1_010, // R4
        9'b1_0_0_1_0_0_100, // R5 master address acked
        9'b1_0_0_0_1_0_100, // R6 ack continues
        9'b1_0_0_0_1_1_001, // R7 nack -> stop
        9'b1_0_0_0_1_0_000, // R7 frozen
        9'b1_1_0_1_0_0_000, // R5 read direction: no load
        9'b1_0_0_1_0_1_001, // R7 refused address
        9'b1_0_0_1_0_0_100, // R5
        9'b1_1_1_0_0_0_000  // R11 addr_match ignored in master mode
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive one cycle at the falling edge; returns after the next rising edge
    task automatic step(input logic m, input logic d, input logic am, input logic as_,
                        input logic bd, input logic ak, input logic wr, input logic [DW-1:0] wd,
                        input string req, input logic [2:0] exp_out);
        @(negedge clk);
        master_mode = m; dir_read = d; addr_match = am; addr_sent = as_;
        byte_done = bd; rx_ack = ak; cpu_wr = wr; cpu_wdata = wd;
        #1;
        chk(req, {load_strobe, release_sda, stop_req}, exp_out);
        @(posedge clk); #1;
    endtask

    task automatic quiet();
        @(negedge clk);
        addr_match = 0; addr_sent = 0; byte_done = 0; cpu_wr = 0; rx_ack = 0;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset outputs", {load_strobe, release_sda, stop_req, tx_empty}, 0);
        chk("R1 reset shift_data", shift_data, 0);
        @(negedge clk); rst_n = 1; enable = 1;
        @(posedge clk); #1;
        chk("R1 after release", {tx_empty, shift_data}, 0);
        step(0, 0, 0, 0, 0, 0, 1, 8'hA5, "R8 write", 3'b000);
        chk("R8 empty stays 0 after write", tx_empty, 0);

        for (int i = 0; i < 16; i++) begin
            step(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3],
                 0, 8'h00, $sformatf("R2-R7 table row %0d", i), VEC[i][2:0]);
        end
        quiet();
        @(posedge clk); #1;
        chk("R2 shift_data from table", shift_data, 8'hA5);

        // R10: disabled write and call are ignored
        @(negedge clk); enable = 0;
        step(0, 1, 1, 0, 0, 0, 1, 8'h3C, "R10 call ignored while disabled", 3'b000);
        quiet(); enable = 1;
        step(0, 1, 1, 0, 0, 0, 0, 8'h00, "R2 slave call", 3'b100);
        chk("R10 write blocked: shift_data", shift_data, 8'hA5);
        chk("R8 empty after load", tx_empty, 1);

        step(0, 0, 0, 0, 0, 0, 1, 8'h5A, "R8 write", 3'b000);
        chk("R8 write clears empty", tx_empty, 0);
        step(0, 0, 0, 0, 1, 1, 0, 8'h00, "R4 nack release", 3'b010);
        chk("R9 empty stays 0 on nack", tx_empty, 0);
        step(0, 1, 1, 0, 0, 0, 0, 8'h00, "R2 recall", 3'b100);
        chk("R2 shift new byte", shift_data, 8'h5A);
        chk("R8 empty set", tx_empty, 1);

        step(0, 0, 0, 0, 1, 0, 1, 8'h77, "R3 load with write", 3'b100);
        chk("R8 load takes old byte", shift_data, 8'h5A);
        chk("R8 write wins over load", tx_empty, 0);
        step(0, 0, 0, 0, 1, 0, 0, 8'h00, "R3 continue", 3'b100);
        chk("R3 shift next byte", shift_data, 8'h77);
        chk("R8 empty set again", tx_empty, 1);

        // R11 addr_sent ignored in slave mode
        step(0, 0, 0, 1, 0, 1, 0, 8'h00, "R11 addr_sent in slave mode", 3'b000);
        quiet();
        @(posedge clk); #1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule